// File: doc/BRIEF.md
# Flow-Through Burst Static RAM

This block is a synthesizable behavioural model of a single-clock synchronous static RAM. Every input is captured on the rising clock edge: the address, the write data and all control signals. Read data is not registered. In the cycle after the address is captured, the stored word flows straight from the array to the output. The word width and the array depth are parameters. The word is always split into four equal byte lanes, for example 8-bit lanes for a 32-bit word and 9-bit lanes for a 36-bit word.

An address strobe loads a new base address and clears an internal two-bit beat counter. An advance input then steps the counter by one beat on each clock. The counter generates the two low address bits, so a burst walks through the four words of an aligned block. The order is either interleaved (start offset XOR beat) or linear (start offset plus beat, modulo 4). It is chosen by a mode input that is latched together with the base address. Each write covers any subset of the four lanes, selected by per-lane enables. A global write input writes all four lanes. A write sampled at one edge is committed to the array at the next edge, with no handshake from the user. Three chip enables and a sleep input gate access. While access is gated, the output enable is low and the stored contents are kept.

Top module: `flow_burst_sram`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `rdOe` is 0 and no write reaches the array.
- R2: In the cycle after an edge where `addrLoad`=1 with the chip selected and no write requested, `rdOe`=1 and `rdData` equals the word stored at the loaded address. There is no extra output register.
- R3: With `burstLinear`=0 latched at the load, beat n of the burst addresses low bits `start[1:0] XOR n`. The upper address bits are unchanged.
- R4: With `burstLinear`=1 latched at the load, beat n addresses low bits `(start[1:0] + n) mod 4`. The burst wraps inside its aligned 4-word block.
- R5: The beat counter advances by one on each edge with `burstAdv`=1 and `addrLoad`=0. With neither input set, the address holds. `addrLoad` takes precedence over `burstAdv` and restarts the burst at beat 0.
- R6: `byteWrEn[i]`=1 writes lane i, which is bits `[i*DATA_W/4 +: DATA_W/4]`. Lanes whose bit is 0 keep their old contents.
- R7: `writeGlobal`=1 writes all four lanes, whatever the value of `byteWrEn`.
- R8: A write sampled at edge k is in the array by edge k+1, so a read loaded at edge k+1 from that word returns the new data. In the cycle after a write is sampled, `rdOe` is 0.
- R9: A load selects the chip only if `chipEn1`=1, `chipEn2N`=0 and `chipEn3`=1 at that edge. If the chip is not selected, `rdOe` stays 0 and writes are ignored until a later load selects it. Advancing the burst keeps the current selection.
- R10: When `sleep`=1 is sampled at an edge, `rdOe` is 0 in the following cycle and any write sampled at that edge is discarded. Stored contents are kept.
- R11: Whenever `rdOe` is 0, `rdData` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control registers |
| addr | input | ADDR_W | Word address, captured when `addrLoad` is 1 |
| addrLoad | input | 1 | Loads a new base address and restarts the burst |
| burstAdv | input | 1 | Steps the burst by one beat |
| burstLinear | input | 1 | Burst order: 0 interleaved, 1 linear; latched at load |
| chipEn1 | input | 1 | Chip enable, active high |
| chipEn2N | input | 1 | Chip enable, active low |
| chipEn3 | input | 1 | Chip enable, active high |
| writeGlobal | input | 1 | Writes all four lanes |
| byteWrEn | input | 4 | Per-lane write enables |
| sleep | input | 1 | Power-down: blocks reads and writes |
| wrData | input | DATA_W | Write data, captured on every edge |
| rdData | output | DATA_W | Flow-through read data, zero when not driven |
| rdOe | output | 1 | High when the data bus is driven |

## Verification
The delicate overlap is a write commit landing on the same edge that loads a new address or advances the burst. The commit must use the address captured with the write request, and the new address takes effect only afterwards. The bench provokes this by filling the array with back-to-back write loads, by running write bursts with `burstAdv`, and by loading a read of a just-written word on the very next edge. A behavioural reference model, built on a per-burst address queue and a plain word array, predicts `rdOe` and `rdData` for every cycle. Each prediction is compared with the ports half a clock after each edge.

// File: rtl/fsram_pkg.sv
package fsram_pkg;

  // The word is always split into this many byte lanes.
  localparam int LANES = 4;

  // Strobes from the control to the datapath for the current cycle.
  typedef struct packed {
    logic             commit;    // a write is pending to the current address
    logic [LANES-1:0] laneMask;  // lanes touched by that write
    logic             drive;     // read data is driven onto the bus
  } accessStrb_t;

endpackage

// File: rtl/fsram_burst_gen.sv
// Low two address bits for a given burst beat.
module fsram_burst_gen (
  input  logic [1:0] startOff,
  input  logic [1:0] beatCnt,
  input  logic       linMode,
  output logic [1:0] beatOff
);

  logic [1:0] linOff;
  logic [1:0] ilvOff;

  assign linOff  = startOff + beatCnt;  // wraps modulo 4
  assign ilvOff  = startOff ^ beatCnt;
  assign beatOff = linMode ? linOff : ilvOff;

endmodule

// File: rtl/fsram_ctrl.sv
// Input registers, burst counter and access gating.
module fsram_ctrl
  import fsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addrLoad,
  input  logic              burstAdv,
  input  logic              burstLinear,
  input  logic              chipEn1,
  input  logic              chipEn2N,
  input  logic              chipEn3,
  input  logic              writeGlobal,
  input  logic [LANES-1:0]  byteWrEn,
  input  logic              sleep,
  output logic [ADDR_W-1:0] effAddr,
  output logic              burstLinQ,
  output accessStrb_t       strb
);

  logic [ADDR_W-1:0] baseQ;
  logic [1:0]        beatQ;
  logic              selQ;
  logic              sleepQ;
  logic              wrQ;
  logic [LANES-1:0]  maskQ;
  logic              allEnabled;
  logic [1:0]        lowBits;

  assign allEnabled = chipEn1 & ~chipEn2N & chipEn3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ     <= '0;
      beatQ     <= '0;
      selQ      <= 1'b0;
      burstLinQ <= 1'b0;
      sleepQ    <= 1'b0;
      wrQ       <= 1'b0;
      maskQ     <= '0;
    end else begin
      if (addrLoad) begin
        baseQ     <= addr;
        beatQ     <= '0;
        selQ      <= allEnabled;
        burstLinQ <= burstLinear;
      end else if (burstAdv) begin
        beatQ <= beatQ + 2'd1;
      end
      sleepQ <= sleep;
      wrQ    <= writeGlobal | (|byteWrEn);
      maskQ  <= writeGlobal ? {LANES{1'b1}} : byteWrEn;
    end
  end

  fsram_burst_gen burstGen (
    .startOff (baseQ[1:0]),
    .beatCnt  (beatQ),
    .linMode  (burstLinQ),
    .beatOff  (lowBits)
  );

  assign effAddr = {baseQ[ADDR_W-1:2], lowBits};

  always_comb begin
    strb.commit   = selQ & ~sleepQ & wrQ;
    strb.laneMask = maskQ;
    strb.drive    = selQ & ~sleepQ & ~wrQ;
  end

endmodule

// File: rtl/fsram_array.sv
// Storage array, lane-merged late write, flow-through read.
module fsram_array
  import fsram_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  accessStrb_t       strb,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdOe
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] curWord;
  logic [DATA_W-1:0] mergedWord;

  always_ff @(posedge clk) begin
    dataQ <= wrData;
  end

  assign curWord = mem[effAddr];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign mergedWord[g*LANE_W +: LANE_W] =
      strb.laneMask[g] ? dataQ[g*LANE_W +: LANE_W] : curWord[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (strb.commit) mem[effAddr] <= mergedWord;
  end

  assign rdOe   = strb.drive;
  assign rdData = strb.drive ? curWord : '0;

endmodule

// File: rtl/flow_burst_sram.sv
module flow_burst_sram
  import fsram_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addrLoad,
  input  logic              burstAdv,
  input  logic              burstLinear,
  input  logic              chipEn1,
  input  logic              chipEn2N,
  input  logic              chipEn3,
  input  logic              writeGlobal,
  input  logic [3:0]        byteWrEn,
  input  logic              sleep,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdOe
);

  logic [ADDR_W-1:0] effAddr;
  logic              burstLinQ;
  accessStrb_t       strb;

  fsram_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .addr        (addr),
    .addrLoad    (addrLoad),
    .burstAdv    (burstAdv),
    .burstLinear (burstLinear),
    .chipEn1     (chipEn1),
    .chipEn2N    (chipEn2N),
    .chipEn3     (chipEn3),
    .writeGlobal (writeGlobal),
    .byteWrEn    (byteWrEn),
    .sleep       (sleep),
    .effAddr     (effAddr),
    .burstLinQ   (burstLinQ),
    .strb        (strb)
  );

  fsram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) array (
    .clk     (clk),
    .strb    (strb),
    .effAddr (effAddr),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdOe    (rdOe)
  );

endmodule

// File: rtl/fsram_checker.sv
module fsram_checker #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              addrLoad,
  input logic              burstAdv,
  input logic              chipEn1,
  input logic              writeGlobal,
  input logic [3:0]        byteWrEn,
  input logic              sleep,
  input logic [DATA_W-1:0] rdData,
  input logic              rdOe,
  input logic [ADDR_W-1:0] effAddr,
  input logic              burstLinQ
);

  // R2: a load puts the captured address on the array.
  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    addrLoad |=> effAddr == $past(addr));

  // R4: a linear advance steps the low bits by one.
  p_linear_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!addrLoad && burstAdv && burstLinQ) |=> effAddr[1:0] == $past(effAddr[1:0]) + 2'd1);

  // R4: without a load, the burst stays within its block.
  p_block_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    !addrLoad |=> effAddr[ADDR_W-1:2] == $past(effAddr[ADDR_W-1:2]));

  // R5: no load and no advance means the address holds.
  p_hold_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!addrLoad && !burstAdv) |=> $stable(effAddr));

  // R8: the cycle after a write request does not drive the bus.
  p_write_no_drive_r8: assert property (@(posedge clk) disable iff (!rstN)
    (writeGlobal || (|byteWrEn)) |=> !rdOe);

  // R9: a load with the first enable off deselects.
  p_deselect_r9: assert property (@(posedge clk) disable iff (!rstN)
    (addrLoad && !chipEn1) |=> !rdOe);

  // R10: sleep blocks the bus.
  p_sleep_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> !rdOe);

  // R11: the undriven bus reads as zero.
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rdOe |-> rdData == '0);

endmodule

bind flow_burst_sram fsram_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk (
  .clk         (clk),
  .rstN        (rstN),
  .addr        (addr),
  .addrLoad    (addrLoad),
  .burstAdv    (burstAdv),
  .chipEn1     (chipEn1),
  .writeGlobal (writeGlobal),
  .byteWrEn    (byteWrEn),
  .sleep       (sleep),
  .rdData      (rdData),
  .rdOe        (rdOe),
  .effAddr     (effAddr),
  .burstLinQ   (burstLinQ)
);

// File: tb/flow_burst_sram_test.sv
module flow_burst_sram_test;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 36;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LW     = DATA_W / 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic [ADDR_W-1:0] addr;
  logic              addrLoad, burstAdv, burstLinear;
  logic              chipEn1, chipEn2N, chipEn3;
  logic              writeGlobal;
  logic [3:0]        byteWrEn;
  logic              sleep;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] rdData;
  logic              rdOe;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";
  bit done = 0;

  // reference model state
  logic [DATA_W-1:0] refMem [DEPTH];
  int                refSeq [$];
  int                refIdx;
  bit                refSel, refSleep, refWr;
  logic [3:0]        refMask;
  logic [DATA_W-1:0] refData;

  always #(CLK_PERIOD/2) clk = ~clk;

  flow_burst_sram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .addrLoad(addrLoad), .burstAdv(burstAdv),
    .burstLinear(burstLinear), .chipEn1(chipEn1), .chipEn2N(chipEn2N), .chipEn3(chipEn3),
    .writeGlobal(writeGlobal), .byteWrEn(byteWrEn), .sleep(sleep), .wrData(wrData),
    .rdData(rdData), .rdOe(rdOe)
  );

  function automatic logic [DATA_W-1:0] pat(input int i, input int salt);
    return DATA_W'((i * 36'h1_0203_0405) ^ (salt * 36'h9_8765_4321) ^ 36'h5A5A5);
  endfunction

  function automatic int curAddr();
    return (refSeq.size() > 0) ? refSeq[refIdx] : 0;
  endfunction

  task automatic compare();
    bit expOe;
    logic [DATA_W-1:0] expData;
    expOe   = refSel && !refSleep && !refWr;
    expData = expOe ? refMem[curAddr()] : '0;
    checks++;
    if (rdOe !== expOe || rdData !== expData) begin
      failures++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", curReq, rdOe, rdData, expOe, expData);
    end
  endtask

  // One clock: update the model at the edge, compare half a period later.
  task automatic cycle();
    @(posedge clk);
    if (refSel && !refSleep && refWr) begin
      for (int l = 0; l < 4; l++)
        if (refMask[l]) refMem[curAddr()][l*LW +: LW] = refData[l*LW +: LW];
    end
    if (addrLoad) begin
      refSel = chipEn1 && !chipEn2N && chipEn3;
      refSeq.delete();
      for (int n = 0; n < 4; n++) begin
        int low;
        low = burstLinear ? ((int'(addr[1:0]) + n) % 4) : (int'(addr[1:0]) ^ n);
        refSeq.push_back((int'(addr) & ~3) | low);
      end
      refIdx = 0;
    end else if (burstAdv) begin
      refIdx = (refIdx + 1) % 4;
    end
    refSleep = sleep;
    refWr    = writeGlobal || (byteWrEn != 0);
    refMask  = writeGlobal ? 4'hF : byteWrEn;
    refData  = wrData;
    @(negedge clk);
    compare();
  endtask

  task automatic drive(input bit ld, input bit adv, input bit lin, input int a,
                       input bit glob, input logic [3:0] be, input logic [DATA_W-1:0] d,
                       input bit e1 = 1, input bit e2n = 0, input bit e3 = 1, input bit slp = 0);
    addrLoad = ld; burstAdv = adv; burstLinear = lin; addr = ADDR_W'(a);
    writeGlobal = glob; byteWrEn = be; wrData = d;
    chipEn1 = e1; chipEn2N = e2n; chipEn3 = e3; sleep = slp;
    cycle();
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 4'h0, '0);
  endtask

  initial begin
    rstN = 1'b0;
    addrLoad = 0; burstAdv = 0; burstLinear = 0; addr = '0;
    chipEn1 = 0; chipEn2N = 1; chipEn3 = 0; writeGlobal = 0; byteWrEn = 0;
    sleep = 0; wrData = '0;
    refSel = 0; refSleep = 0; refWr = 0; refMask = 0; refData = '0; refIdx = 0;
    repeat (3) @(negedge clk);
    curReq = "R1";
    compare();
    rstN = 1'b1;
    compare();
    idle();

    // fill the array with back-to-back global writes (R7, R8)
    curReq = "R7";
    for (int i = 0; i < DEPTH; i++) drive(1, 0, 0, i, 1, 4'h0, pat(i, 0));
    idle();

    // single flow-through read and hold (R2, R5)
    curReq = "R2";
    drive(1, 0, 0, 5, 0, 4'h0, '0);
    curReq = "R5";
    idle(); idle();

    // interleaved bursts from each start offset (R3)
    curReq = "R3";
    for (int s = 0; s < 4; s++) begin
      drive(1, 0, 0, 8 + s, 0, 4'h0, '0);
      repeat (5) drive(0, 1, 0, 0, 0, 4'h0, '0);
    end

    // linear bursts with wrap (R4)
    curReq = "R4";
    for (int s = 0; s < 4; s++) begin
      drive(1, 0, 1, 20 + s, 0, 4'h0, '0);
      repeat (5) drive(0, 1, 1, 0, 0, 4'h0, '0);
    end

    // load beats advance on the same edge (R5)
    curReq = "R5";
    drive(1, 0, 1, 30, 0, 4'h0, '0);
    drive(0, 1, 0, 0, 0, 4'h0, '0);
    drive(1, 1, 0, 45, 0, 4'h0, '0);
    drive(0, 1, 0, 0, 0, 4'h0, '0);
    idle();

    // lane writes, then read back (R6)
    curReq = "R6";
    drive(1, 0, 0, 12, 0, 4'b0101, pat(99, 1));
    drive(1, 0, 0, 12, 0, 4'h0, '0);
    drive(1, 0, 0, 13, 0, 4'b1000, pat(98, 2));
    drive(1, 0, 0, 13, 0, 4'h0, '0);
    drive(1, 0, 0, 14, 0, 4'b0010, pat(97, 3));
    drive(1, 0, 0, 14, 0, 4'h0, '0);

    // global write overrides lane enables (R7)
    curReq = "R7";
    drive(1, 0, 0, 15, 1, 4'b0001, pat(96, 4));
    drive(1, 0, 0, 15, 0, 4'h0, '0);

    // write burst, then immediate read-back of the last word (R8)
    curReq = "R8";
    drive(1, 0, 1, 33, 1, 4'h0, pat(1, 5));
    drive(0, 1, 1, 0, 1, 4'h0, pat(2, 5));
    drive(0, 1, 1, 0, 0, 4'b1100, pat(3, 5));
    drive(1, 0, 0, 35, 0, 4'h0, '0);
    drive(1, 0, 0, 34, 0, 4'h0, '0);
    drive(1, 0, 1, 32, 0, 4'h0, '0);
    repeat (4) drive(0, 1, 1, 0, 0, 4'h0, '0);

    // each enable off blocks reads and writes (R9)
    curReq = "R9";
    drive(1, 0, 0, 40, 1, 4'h0, pat(7, 6), 0, 0, 1);
    drive(0, 1, 0, 0, 1, 4'h0, pat(8, 6));
    drive(1, 0, 0, 41, 1, 4'h0, pat(9, 6), 1, 1, 1);
    drive(1, 0, 0, 42, 1, 4'h0, pat(10, 6), 1, 0, 0);
    drive(1, 0, 0, 40, 0, 4'h0, '0, 0, 0, 1);
    drive(0, 1, 0, 0, 0, 4'h0, '0);
    for (int i = 40; i < 44; i++) drive(1, 0, 0, i, 0, 4'h0, '0);

    // sleep during a burst, with a write attempt (R10, R11)
    curReq = "R10";
    drive(1, 0, 0, 50, 0, 4'h0, '0);
    drive(0, 1, 0, 0, 1, 4'h0, pat(11, 7), 1, 0, 1, 1);
    drive(0, 0, 0, 0, 0, 4'h0, '0, 1, 0, 1, 1);
    curReq = "R11";
    drive(0, 1, 0, 0, 0, 4'h0, '0);
    drive(0, 1, 0, 0, 0, 4'h0, '0);
    curReq = "R10";
    for (int i = 48; i < 52; i++) drive(1, 0, 0, i, 0, 4'h0, '0);

    // random mix, reads and writes interleaved
    curReq = "R8";
    for (int k = 0; k < 300; k++) begin
      bit ld;
      bit wr;
      ld = ($urandom % 3) == 0;
      wr = ($urandom % 3) == 0;
      drive(ld, $urandom % 2, $urandom % 2, $urandom % DEPTH, wr && ($urandom % 2),
            wr ? 4'($urandom) : 4'h0, pat(k, 8), 1, ($urandom % 8) == 0, 1, ($urandom % 10) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule